// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of leaf translations for 39-bit, three-level virtual memory. A memory pipeline presents a virtual page number together with an address-space tag and a guest tag. In the same cycle it gets back a hit flag, the physical page number, the stored permission and attribute bits, and the size of the page that matched.

A page-table walker writes new leaf translations through a refill port. A leaf can be a 4 KB page, a 64 KB contiguous page, a 2 MB page or a 1 GB page. The victim slot is the lowest-numbered free slot. When every slot is in use, a round-robin pointer picks the victim.

A flush port serves fence operations. It removes every entry, or only the entries selected by address, by address-space tag, or by both. The guest tag keeps translations belonging to different guests apart, both on lookup and on flush.

Top module: `xlat_tlb`

## Requirements
- R1: After reset the buffer is empty, and every lookup misses until a refill has been written.
- R2: A lookup hits only when the entry is valid and its guest tag equals the lookup's guest tag. In addition, either its address-space tag must equal the lookup's tag or the entry must be global.
- R3: The refill size code selects the page size: 0 is 4 KB, 1 is 64 KB, 2 is 2 MB and 3 is 1 GB. The tag compare ignores the low 0, 4, 9 or 18 page-number bits respectively.
- R4: A 64 KB entry matches every page number that shares all bits above the low four.
- R5: On a hit to a page larger than 4 KB, the output physical page number takes its ignored low bits from the lookup page number and its other bits from the stored number.
- R6: On a hit, the 8-bit permission field and the size code are returned exactly as they were written. The permission field is laid out as bit0 read, bit1 write, bit2 execute, bit3 user, bit4 accessed, bit5 dirty, and bits 7:6 memory type.
- R7: A flush with neither the address nor the tag qualifier set removes every entry, whatever its guest tag.
- R8: A flush qualified by tag only removes the non-global entries whose address-space tag and guest tag both match. Global entries are kept.
- R9: A flush qualified by address only removes the entries of the given guest whose page covers the flush page number, in every address space. The coverage test uses each entry's own page size.
- R10: A flush qualified by both address and tag removes the entries of the given guest that cover the address and either carry the tag or are global.
- R11: A refill is written into the lowest-numbered invalid slot when one exists, and the round-robin pointer does not move.
- R12: When all slots are valid, a refill replaces the slot named by the round-robin pointer, which starts at 0 and advances by one (wrapping) for each such replacement.
- R13: When a flush and a refill arrive in the same cycle, the flush acts on the old contents first, and the refilled entry survives.
- R14: A refill becomes visible to lookups from the cycle after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | 27 | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_vmid | input | VMID_W | Lookup guest tag |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_ppn | output | 44 | Translated physical page number |
| lk_perm | output | 8 | Stored permission and attribute bits |
| lk_size | output | 2 | Size code of the matching entry |
| rf_valid | input | 1 | Install a leaf entry this cycle |
| rf_vpn | input | 27 | Virtual page number of the new entry |
| rf_asid | input | ASID_W | Address-space tag of the new entry |
| rf_vmid | input | VMID_W | Guest tag of the new entry |
| rf_global | input | 1 | New entry matches every address-space tag |
| rf_ppn | input | 44 | Physical page number of the new entry |
| rf_perm | input | 8 | Permission and attribute bits of the new entry |
| rf_size | input | 2 | Size code of the new entry |
| fl_valid | input | 1 | Perform a flush this cycle |
| fl_use_addr | input | 1 | Restrict the flush to entries covering fl_vpn |
| fl_use_asid | input | 1 | Restrict the flush to address-space tag fl_asid |
| fl_vpn | input | 27 | Flush page number |
| fl_asid | input | ASID_W | Flush address-space tag |
| fl_vmid | input | VMID_W | Flush guest tag (used by qualified flushes) |

## Verification
A wrong valid bit or a wrong stored tag shows up as an unexpected hit or miss on the very next lookup of the affected page. No output shows a wrong round-robin pointer at once. It only shows when the buffer is full, through which earlier translation disappears after the next refill, so the bench fills every slot and then probes the neighbours of each victim. A wrong size mask shows up in two ways: as a miss on a page just inside a superpage, and as wrong low bits in the returned physical page number, both in the same cycle as the lookup.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

  localparam int VPN_W   = 27;
  localparam int PPN_W   = 44;
  localparam int PERM_W  = 8;
  localparam int LVL_W   = 9;
  localparam int NAPOT_W = 4;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_2M  = 2'd2,
    PG_1G  = 2'd3
  } pg_size_e;

  // Bits of the page number that take part in the tag compare.
  function automatic logic [VPN_W-1:0] keep_mask(input pg_size_e sz);
    logic [VPN_W-1:0] m;
    m = {VPN_W{1'b1}};
    case (sz)
      PG_64K:  m = {VPN_W{1'b1}} << NAPOT_W;
      PG_2M:   m = {VPN_W{1'b1}} << LVL_W;
      PG_1G:   m = {VPN_W{1'b1}} << (2 * LVL_W);
      default: m = {VPN_W{1'b1}};
    endcase
    return m;
  endfunction

endpackage

// File: rtl/xlat_tlb_cmp.sv
module xlat_tlb_cmp
  import xlat_tlb_pkg::*;
#(
  parameter int ASID_W = 16,
  parameter int VMID_W = 14
) (
  input  logic              e_valid,
  input  logic [VPN_W-1:0]  e_vpn,
  input  logic [ASID_W-1:0] e_asid,
  input  logic [VMID_W-1:0] e_vmid,
  input  logic              e_glob,
  input  pg_size_e          e_size,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic              fl_use_addr,
  input  logic              fl_use_asid,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic [VMID_W-1:0] fl_vmid,
  output logic              lk_match,
  output logic              fl_match
);

  logic [VPN_W-1:0] mask;
  logic             fl_addr_ok;
  logic             fl_id_ok;

  always_comb begin
    mask     = keep_mask(e_size);
    lk_match = e_valid && (e_vmid == lk_vmid) && (e_glob || (e_asid == lk_asid)) &&
               (((e_vpn ^ lk_vpn) & mask) == '0);

    fl_addr_ok = !fl_use_addr || (((e_vpn ^ fl_vpn) & mask) == '0);
    if (!fl_use_asid)     fl_id_ok = 1'b1;
    else if (fl_use_addr) fl_id_ok = e_glob || (e_asid == fl_asid);
    else                  fl_id_ok = !e_glob && (e_asid == fl_asid);

    if (!fl_use_addr && !fl_use_asid) fl_match = e_valid;
    else fl_match = e_valid && (e_vmid == fl_vmid) && fl_addr_ok && fl_id_ok;
  end

endmodule

// File: rtl/xlat_tlb_victim.sv
module xlat_tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] occupied,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   victim,
  output logic               from_rr
);

  always_comb begin
    victim  = rr_ptr;
    from_rr = 1'b1;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!occupied[i]) begin
        victim  = IDX_W'(i);
        from_rr = 1'b0;
      end
    end
  end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 16,
  parameter int VMID_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [26:0]       lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VMID_W-1:0] lk_vmid,
  output logic              lk_hit,
  output logic [43:0]       lk_ppn,
  output logic [7:0]        lk_perm,
  output logic [1:0]        lk_size,
  input  logic              rf_valid,
  input  logic [26:0]       rf_vpn,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [VMID_W-1:0] rf_vmid,
  input  logic              rf_global,
  input  logic [43:0]       rf_ppn,
  input  logic [7:0]        rf_perm,
  input  logic [1:0]        rf_size,
  input  logic              fl_valid,
  input  logic              fl_use_addr,
  input  logic              fl_use_asid,
  input  logic [26:0]       fl_vpn,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic [VMID_W-1:0] fl_vmid
);

  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q, valid_d, valid_post, kill, wr_en;
  logic [ENTRIES-1:0] lk_match, fl_match;
  logic [IDX_W-1:0]   rr_q, rr_d, victim, sel;
  logic               from_rr, state_en, found;

  logic [VPN_W-1:0]  e_vpn  [ENTRIES];
  logic [PPN_W-1:0]  e_ppn  [ENTRIES];
  logic [ASID_W-1:0] e_asid [ENTRIES];
  logic [VMID_W-1:0] e_vmid [ENTRIES];
  logic              e_glob [ENTRIES];
  logic [PERM_W-1:0] e_perm [ENTRIES];
  pg_size_e          e_size [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    xlat_tlb_cmp #(.ASID_W(ASID_W), .VMID_W(VMID_W)) u_cmp (
      .e_valid     (valid_q[g]),
      .e_vpn       (e_vpn[g]),
      .e_asid      (e_asid[g]),
      .e_vmid      (e_vmid[g]),
      .e_glob      (e_glob[g]),
      .e_size      (e_size[g]),
      .lk_vpn      (lk_vpn),
      .lk_asid     (lk_asid),
      .lk_vmid     (lk_vmid),
      .fl_use_addr (fl_use_addr),
      .fl_use_asid (fl_use_asid),
      .fl_vpn      (fl_vpn),
      .fl_asid     (fl_asid),
      .fl_vmid     (fl_vmid),
      .lk_match    (lk_match[g]),
      .fl_match    (fl_match[g])
    );

    // Entry payload: written only on install, no reset needed.
    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        e_vpn[g]  <= rf_vpn;
        e_ppn[g]  <= rf_ppn;
        e_asid[g] <= rf_asid;
        e_vmid[g] <= rf_vmid;
        e_glob[g] <= rf_global;
        e_perm[g] <= rf_perm;
        e_size[g] <= pg_size_e'(rf_size);
      end
    end
  end

  // Victim is chosen from the occupancy left after this cycle's flush.
  xlat_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .occupied (valid_post),
    .rr_ptr   (rr_q),
    .victim   (victim),
    .from_rr  (from_rr)
  );

  always_comb begin
    kill       = fl_valid ? fl_match : '0;
    valid_post = valid_q & ~kill;
    wr_en      = '0;
    if (rf_valid) wr_en[victim] = 1'b1;
    valid_d  = valid_post | wr_en;
    rr_d     = rr_q;
    if (rf_valid && from_rr) begin
      rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
    state_en = fl_valid | rf_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (state_en) begin
      valid_q <= valid_d;
      rr_q    <= rr_d;
    end
  end

  // Lookup: lowest-numbered matching slot wins.
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && lk_match[i]) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end

  logic [VPN_W-1:0] out_mask;

  always_comb begin
    out_mask = keep_mask(e_size[sel]);
    lk_hit   = found;
    lk_ppn   = {e_ppn[sel][PPN_W-1:VPN_W],
                (e_ppn[sel][VPN_W-1:0] & out_mask) | (lk_vpn & ~out_mask)};
    lk_perm  = e_perm[sel];
    lk_size  = e_size[sel];
  end

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [26:0]        lk_vpn,
  input logic               lk_hit,
  input logic [43:0]        lk_ppn,
  input logic [1:0]         lk_size,
  input logic               rf_valid,
  input logic               fl_valid,
  input logic               fl_use_addr,
  input logic               fl_use_asid,
  input logic [ENTRIES-1:0] valid_q
);

  AST_GIGA_LOW_FROM_VPN: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_size == 2'd3) |-> (lk_ppn[17:0] == lk_vpn[17:0])); // R5

  AST_NAPOT_LOW_FROM_VPN: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_size == 2'd1) |-> (lk_ppn[3:0] == lk_vpn[3:0])); // R4

  AST_FLUSH_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !fl_use_addr && !fl_use_asid && !rf_valid) |=> (valid_q == '0)); // R7

  AST_FREE_SLOT_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && !fl_valid && !(&valid_q)) |=>
      ($countones(valid_q) == $past($countones(valid_q)) + 1)); // R11

  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && !fl_valid && (&valid_q)) |=> (&valid_q)); // R12

  AST_REFILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid |=> (valid_q != '0)); // R14

endmodule

bind xlat_tlb xlat_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_vpn      (lk_vpn),
  .lk_hit      (lk_hit),
  .lk_ppn      (lk_ppn),
  .lk_size     (lk_size),
  .rf_valid    (rf_valid),
  .fl_valid    (fl_valid),
  .fl_use_addr (fl_use_addr),
  .fl_use_asid (fl_use_asid),
  .valid_q     (valid_q)
);

// File: tb/tb_xlat_tlb.sv
`timescale 1ns/1ps
module tb_xlat_tlb;

  logic        clk;
  logic        rst_n;
  logic [26:0] lk_vpn;
  logic [15:0] lk_asid;
  logic [13:0] lk_vmid;
  logic        lk_hit;
  logic [43:0] lk_ppn;
  logic [7:0]  lk_perm;
  logic [1:0]  lk_size;
  logic        rf_valid;
  logic [26:0] rf_vpn;
  logic [15:0] rf_asid;
  logic [13:0] rf_vmid;
  logic        rf_global;
  logic [43:0] rf_ppn;
  logic [7:0]  rf_perm;
  logic [1:0]  rf_size;
  logic        fl_valid;
  logic        fl_use_addr;
  logic        fl_use_asid;
  logic [26:0] fl_vpn;
  logic [15:0] fl_asid;
  logic [13:0] fl_vmid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  xlat_tlb dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [26:0] vpn;
    logic [15:0] asid;
    logic [13:0] vmid;
    logic        hit;
    logic [43:0] ppn;
    logic [7:0]  perm;
    logic [1:0]  size;
    logic [3:0]  req;
  } lk_vec_t;

  // Expected results against the five entries installed before the walk.
  localparam lk_vec_t LK_TAB [11] = '{
    '{27'h0001234, 16'd5, 14'd1, 1'b1, 44'h000000ABCDE, 8'h13, 2'd0, 4'd6},  // R6 R1
    '{27'h0001234, 16'd6, 14'd1, 1'b0, 44'h0,           8'h00, 2'd0, 4'd2},  // R2
    '{27'h0001234, 16'd5, 14'd2, 1'b1, 44'h00000000777, 8'h3F, 2'd0, 4'd2},  // R2
    '{27'h0001235, 16'd5, 14'd1, 1'b0, 44'h0,           8'h00, 2'd0, 4'd3},  // R3
    '{27'h0412345, 16'd9, 14'd1, 1'b1, 44'h00000092345, 8'hCF, 2'd3, 4'd5},  // R5 global
    '{27'h0440000, 16'd9, 14'd1, 1'b0, 44'h0,           8'h00, 2'd0, 4'd3},  // R3
    '{27'h00122AB, 16'd7, 14'd1, 1'b1, 44'h000000F40AB, 8'h07, 2'd2, 4'd5},  // R5
    '{27'h0012400, 16'd7, 14'd1, 1'b0, 44'h0,           8'h00, 2'd0, 4'd3},  // R3
    '{27'h000567C, 16'd5, 14'd1, 1'b1, 44'h0000000999C, 8'h33, 2'd1, 4'd4},  // R4
    '{27'h0005680, 16'd5, 14'd1, 1'b0, 44'h0,           8'h00, 2'd0, 4'd4},  // R4
    '{27'h0012200, 16'd5, 14'd1, 1'b0, 44'h0,           8'h00, 2'd0, 4'd2}   // R2
  };

  task automatic note(input bit ok, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic probe(input logic [26:0] v, input logic [15:0] a, input logic [13:0] m,
                       input bit exp_hit, input logic [43:0] exp_ppn, input string what);
    lk_vpn = v; lk_asid = a; lk_vmid = m;
    #1;
    note(lk_hit == exp_hit, {what, " hit"}, 64'(lk_hit), 64'(exp_hit));
    if (exp_hit) note(lk_ppn == exp_ppn, {what, " ppn"}, 64'(lk_ppn), 64'(exp_ppn));
  endtask

  task automatic refill(input logic [26:0] v, input logic [15:0] a, input logic [13:0] m,
                        input bit g, input logic [43:0] p, input logic [7:0] pm,
                        input logic [1:0] sz);
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = v; rf_asid = a; rf_vmid = m;
    rf_global = g; rf_ppn = p; rf_perm = pm; rf_size = sz;
    @(negedge clk);
    rf_valid = 1'b0;
  endtask

  task automatic flush(input bit ua, input bit us, input logic [26:0] v,
                       input logic [15:0] a, input logic [13:0] m);
    @(negedge clk);
    fl_valid = 1'b1; fl_use_addr = ua; fl_use_asid = us;
    fl_vpn = v; fl_asid = a; fl_vmid = m;
    @(negedge clk);
    fl_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    lk_vpn = '0; lk_asid = '0; lk_vmid = '0;
    rf_valid = 1'b0; rf_vpn = '0; rf_asid = '0; rf_vmid = '0; rf_global = 1'b0;
    rf_ppn = '0; rf_perm = '0; rf_size = '0;
    fl_valid = 1'b0; fl_use_addr = 1'b0; fl_use_asid = 1'b0;
    fl_vpn = '0; fl_asid = '0; fl_vmid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset.
    @(negedge clk);
    probe(27'h0001234, 16'd5, 14'd1, 1'b0, 44'h0, "R1 reset empty");

    // R14: not visible before the capturing edge, visible after it.
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = 27'h0001234; rf_asid = 16'd5; rf_vmid = 14'd1;
    rf_global = 1'b0; rf_ppn = 44'h000000ABCDE; rf_perm = 8'h13; rf_size = 2'd0;
    probe(27'h0001234, 16'd5, 14'd1, 1'b0, 44'h0, "R14 before edge");
    @(negedge clk);
    rf_valid = 1'b0;
    probe(27'h0001234, 16'd5, 14'd1, 1'b1, 44'h000000ABCDE, "R14 after edge");

    refill(27'h0400000, 16'd5, 14'd1, 1'b1, 44'h00000080000, 8'hCF, 2'd3);
    refill(27'h0012200, 16'd7, 14'd1, 1'b0, 44'h000000F4000, 8'h07, 2'd2);
    refill(27'h0005670, 16'd5, 14'd1, 1'b0, 44'h00000009990, 8'h33, 2'd1);
    refill(27'h0001234, 16'd5, 14'd2, 1'b0, 44'h00000000777, 8'h3F, 2'd0);

    @(negedge clk);
    for (int i = 0; i < 11; i++) begin
      lk_vpn = LK_TAB[i].vpn; lk_asid = LK_TAB[i].asid; lk_vmid = LK_TAB[i].vmid;
      #1;
      note(lk_hit == LK_TAB[i].hit, $sformatf("R%0d vec%0d hit", LK_TAB[i].req, i),
           64'(lk_hit), 64'(LK_TAB[i].hit));
      if (LK_TAB[i].hit) begin
        note(lk_ppn == LK_TAB[i].ppn, $sformatf("R%0d vec%0d ppn", LK_TAB[i].req, i),
             64'(lk_ppn), 64'(LK_TAB[i].ppn));
        // R6: permission and size pass through.
        note(lk_perm == LK_TAB[i].perm, $sformatf("R6 vec%0d perm", i),
             64'(lk_perm), 64'(LK_TAB[i].perm));
        note(lk_size == LK_TAB[i].size, $sformatf("R6 vec%0d size", i),
             64'(lk_size), 64'(LK_TAB[i].size));
      end
      #2;
    end

    // R8: tag-only flush in guest 1, tag 5.
    flush(1'b0, 1'b1, 27'h0, 16'd5, 14'd1);
    probe(27'h0001234, 16'd5, 14'd1, 1'b0, 44'h0, "R8 tagged 4K gone");
    probe(27'h0005678, 16'd5, 14'd1, 1'b0, 44'h0, "R8 tagged 64K gone");
    probe(27'h0400001, 16'd5, 14'd1, 1'b1, 44'h00000080001, "R8 global kept");
    probe(27'h0001234, 16'd5, 14'd2, 1'b1, 44'h00000000777, "R8 other guest kept");
    probe(27'h0012201, 16'd7, 14'd1, 1'b1, 44'h000000F4001, "R8 other tag kept");

    // R9: address-only flush inside the 2 MB page.
    flush(1'b1, 1'b0, 27'h0012210, 16'd0, 14'd1);
    probe(27'h0012201, 16'd7, 14'd1, 1'b0, 44'h0, "R9 covering 2M gone");
    probe(27'h0400001, 16'd3, 14'd1, 1'b1, 44'h00000080001, "R9 non-covering kept");

    // R10: address plus tag flush removes a covering global entry.
    flush(1'b1, 1'b1, 27'h0400010, 16'd3, 14'd1);
    probe(27'h0400001, 16'd3, 14'd1, 1'b0, 44'h0, "R10 covering global gone");
    probe(27'h0001234, 16'd5, 14'd2, 1'b1, 44'h00000000777, "R10 other guest kept");

    // R7: flush everything, ignoring the guest tag.
    flush(1'b0, 1'b0, 27'h0, 16'd0, 14'd0);
    probe(27'h0001234, 16'd5, 14'd2, 1'b0, 44'h0, "R7 all gone");

    // R12: fill all sixteen slots, then replace in round-robin order.
    for (int i = 0; i < 16; i++)
      refill(27'h0000100 + 27'(i), 16'd1, 14'd0, 1'b0, 44'h200 + 44'(i), 8'h01, 2'd0);
    @(negedge clk);
    probe(27'h010F, 16'd1, 14'd0, 1'b1, 44'h20F, "R11 last free slot used");
    refill(27'h0000300, 16'd1, 14'd0, 1'b0, 44'h400, 8'h01, 2'd0);
    probe(27'h0100, 16'd1, 14'd0, 1'b0, 44'h0, "R12 slot0 evicted");
    probe(27'h0101, 16'd1, 14'd0, 1'b1, 44'h201, "R12 slot1 kept");
    probe(27'h0300, 16'd1, 14'd0, 1'b1, 44'h400, "R12 new entry");
    refill(27'h0000301, 16'd1, 14'd0, 1'b0, 44'h401, 8'h01, 2'd0);
    probe(27'h0101, 16'd1, 14'd0, 1'b0, 44'h0, "R12 slot1 evicted next");
    probe(27'h0102, 16'd1, 14'd0, 1'b1, 44'h202, "R12 slot2 kept");

    // R11: a freed slot is preferred over the pointer's victim.
    flush(1'b1, 1'b0, 27'h0000105, 16'd0, 14'd0);
    refill(27'h0000302, 16'd1, 14'd0, 1'b0, 44'h402, 8'h01, 2'd0);
    probe(27'h0102, 16'd1, 14'd0, 1'b1, 44'h202, "R11 pointer victim spared");
    probe(27'h0302, 16'd1, 14'd0, 1'b1, 44'h402, "R11 free slot filled");

    // R13: flush-all and refill in the same cycle.
    @(negedge clk);
    fl_valid = 1'b1; fl_use_addr = 1'b0; fl_use_asid = 1'b0;
    rf_valid = 1'b1; rf_vpn = 27'h0000400; rf_asid = 16'd1; rf_vmid = 14'd0;
    rf_global = 1'b0; rf_ppn = 44'h500; rf_perm = 8'h01; rf_size = 2'd0;
    @(negedge clk);
    fl_valid = 1'b0; rf_valid = 1'b0;
    probe(27'h0400, 16'd1, 14'd0, 1'b1, 44'h500, "R13 refill survives");
    probe(27'h0102, 16'd1, 14'd0, 1'b0, 44'h0, "R13 old entry flushed");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule